// File: doc/BRIEF.md
# ADC Power Mode Sequencer

This controller owns the two low-power control lines of a sampling converter. One line selects a light sleep in which only the voltage reference stays powered. The other selects a deep sleep in which everything, the reference included, is switched off. Sleep and wake requests come from system logic. The controller drives the matching control line and, after a wake request, holds the converter in a settling phase. The settling phase lasts a set number of system clock cycles, and that number depends on which sleep state is being left.

Convert-start requests from the capture logic pass straight through only while the converter is fully awake. While asleep or settling they are dropped, so no sample is ever taken with unsettled circuitry. The settling times are given in nanoseconds. They are turned into cycle counts from a clock-frequency parameter and always rounded up. A parameter records whether the reference is on-chip or supplied from outside, because that changes how long the deep-sleep recovery takes.

An optional auto-sleep mode sends the converter back into light sleep as soon as the data frame of an accepted conversion has been read out.

Top module: `adc_power_seq`

## Requirements
- R1: After reset the block is in the awake state: `nap_o` and `stby_o` low, `ready_o` high, `state_o` = 0.
- R2: In the awake state, `sleep_req` puts the block into light sleep when `sleep_deep` = 0 (`nap_o` high) or into deep sleep when `sleep_deep` = 1 (`stby_o` high), from the next cycle on.
- R3: `conv_start_o` follows `conv_req` in the same cycle while the block is awake, and stays low in every other state.
- R4: After a wake request in light sleep, `ready_o` rises exactly ceil(NAP_WAKE_NS × CLK_HZ / 1e9) cycles after the clock edge at which `nap_o` falls.
- R5: With an on-chip reference (EXT_REF = 0), recovery from deep sleep lasts ceil(STBY_INT_WAKE_NS × CLK_HZ / 1e9) cycles, counted from the edge at which `stby_o` falls.
- R6: With an external reference (EXT_REF = 1), recovery from deep sleep lasts ceil(STBY_EXT_WAKE_NS × CLK_HZ / 1e9) cycles instead.
- R7: A settling time that is not a whole number of cycles is rounded up, never down, and it is always at least one cycle.
- R8: `sleep_req` during settling abandons the wake-up. The block goes to deep sleep if `sleep_deep` = 1 or if the settling began in deep sleep; otherwise it goes to light sleep.
- R9: In light sleep, a deep-sleep request moves the block to deep sleep. In deep sleep, a light-sleep request is ignored and the block stays in deep sleep.
- R10: In a sleep state, `sleep_req` takes priority over `wake_req` in the same cycle.
- R11: With `auto_nap_en` high, `frame_done` after a conversion accepted in the awake state sends the block to light sleep on the next edge. Without such a conversion, or with `auto_nap_en` low, `frame_done` has no effect.
- R12: `state_o` encodes the state as 0 awake, 1 light sleep, 2 deep sleep, 3 settling. `nap_o` is high only in state 1, `stby_o` only in state 2, and `ready_o` only in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Request to enter a sleep state |
| sleep_deep | input | 1 | Sleep depth for `sleep_req`: 1 deep, 0 light |
| wake_req | input | 1 | Request to leave the current sleep state |
| auto_nap_en | input | 1 | Return to light sleep after each read-out frame |
| conv_req | input | 1 | Convert-start request from capture logic |
| frame_done | input | 1 | Read-out of the current frame has finished |
| conv_start_o | output | 1 | Admitted convert-start to the converter |
| ready_o | output | 1 | Converter awake and settled |
| nap_o | output | 1 | Light-sleep control line |
| stby_o | output | 1 | Deep-sleep control line |
| state_o | output | 2 | Current power state code |

## Verification
The settling count matters most. A countdown that is loaded with the wrong value, or that picks the wrong sleep source, moves the rising edge of `ready_o` by at least one cycle. This shows on the first wake-up from that sleep state, and the bench measures the edge to the exact cycle for each source and for each reference type. A wrong state register shows at once on `state_o` and on the two control lines. It also shows as a convert-start that leaks through, or is lost, in the same cycle as `conv_req`. A stale auto-sleep flag shows one edge after `frame_done`.

// File: rtl/adc_power_pkg.sv
package adc_power_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'd0,
        PM_NAP     = 2'd1,
        PM_STANDBY = 2'd2,
        PM_WAKING  = 2'd3
    } pm_state_e;

    // Convert a settling time to clock cycles, rounding up, minimum one.
    function automatic longint unsigned ns_to_cycles(input longint unsigned ns,
                                                     input longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 64'd1 : c;
    endfunction

endpackage

// File: rtl/wake_countdown.sv
module wake_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R4
    count_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(rst_n) && $past(cnt_q) != '0 && !$past(load)) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/conv_admit.sv
module conv_admit (
    input  logic clk,
    input  logic rst_n,
    input  logic awake,
    input  logic conv_req,
    input  logic auto_nap_en,
    output logic conv_start,
    output logic nap_due
);

    logic pend_d, pend_q;

    assign conv_start = conv_req & awake;

    always_comb begin
        pend_d = 1'b0;
        if (awake)
            pend_d = auto_nap_en & (pend_q | conv_start);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign nap_due = pend_q & auto_nap_en;

    // R11
    due_needs_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nap_due) |-> ($past(conv_start) || !$past(auto_nap_en)));

endmodule

// File: rtl/adc_power_seq.sv
module adc_power_seq
    import adc_power_pkg::*;
#(
    parameter int unsigned CLK_HZ           = 100_000_000,
    parameter int unsigned NAP_WAKE_NS      = 300,
    parameter int unsigned STBY_INT_WAKE_NS = 500_000_000,
    parameter int unsigned STBY_EXT_WAKE_NS = 80_000,
    parameter bit          EXT_REF          = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       sleep_deep,
    input  logic       wake_req,
    input  logic       auto_nap_en,
    input  logic       conv_req,
    input  logic       frame_done,
    output logic       conv_start_o,
    output logic       ready_o,
    output logic       nap_o,
    output logic       stby_o,
    output logic [1:0] state_o
);

    localparam longint unsigned NAP_CYC = ns_to_cycles(64'(NAP_WAKE_NS), 64'(CLK_HZ));
    localparam longint unsigned STB_NS  = EXT_REF ? 64'(STBY_EXT_WAKE_NS) : 64'(STBY_INT_WAKE_NS);
    localparam longint unsigned STB_CYC = ns_to_cycles(STB_NS, 64'(CLK_HZ));
    localparam longint unsigned MAX_CYC = (NAP_CYC > STB_CYC) ? NAP_CYC : STB_CYC;
    localparam int              CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] NAP_LOAD = CNT_W'(NAP_CYC - 1);
    localparam logic [CNT_W-1:0] STB_LOAD = CNT_W'(STB_CYC - 1);

    typedef struct packed {
        pm_state_e st;
        logic      from_deep;
    } seq_t;

    seq_t             cur_q, cur_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             nap_due;

    wake_countdown #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    conv_admit u_admit (
        .clk         (clk),
        .rst_n       (rst_n),
        .awake       (cur_q.st == PM_ACTIVE),
        .conv_req    (conv_req),
        .auto_nap_en (auto_nap_en),
        .conv_start  (conv_start_o),
        .nap_due     (nap_due)
    );

    always_comb begin
        cur_d    = cur_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (cur_q.st)
            PM_ACTIVE: begin
                if (sleep_req)
                    cur_d.st = sleep_deep ? PM_STANDBY : PM_NAP;
                else if (frame_done && nap_due)
                    cur_d.st = PM_NAP;
            end
            PM_NAP: begin
                if (sleep_req && sleep_deep) begin
                    cur_d.st = PM_STANDBY;
                end else if (!sleep_req && wake_req) begin
                    cur_d.st        = PM_WAKING;
                    cur_d.from_deep = 1'b0;
                    tmr_load        = 1'b1;
                    tmr_val         = NAP_LOAD;
                end
            end
            PM_STANDBY: begin
                if (!sleep_req && wake_req) begin
                    cur_d.st        = PM_WAKING;
                    cur_d.from_deep = 1'b1;
                    tmr_load        = 1'b1;
                    tmr_val         = STB_LOAD;
                end
            end
            PM_WAKING: begin
                if (sleep_req)
                    cur_d.st = (sleep_deep || cur_q.from_deep) ? PM_STANDBY : PM_NAP;
                else if (tmr_done)
                    cur_d.st = PM_ACTIVE;
            end
            default: cur_d.st = PM_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{st: PM_ACTIVE, from_deep: 1'b0};
        else        cur_q <= cur_d;
    end

    assign state_o = cur_q.st;
    assign ready_o = (cur_q.st == PM_ACTIVE);
    assign nap_o   = (cur_q.st == PM_NAP);
    assign stby_o  = (cur_q.st == PM_STANDBY);

    // Checker-only count of settling cycles
    logic [CNT_W:0] wk_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                  wk_len_q <= '0;
        else if (cur_q.st == PM_WAKING) wk_len_q <= wk_len_q + 1'b1;
        else                         wk_len_q <= '0;
    end

    // R4 R5 R6
    wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && $past(cur_q.st) == PM_WAKING) |->
        (64'(wk_len_q) >= (cur_q.from_deep ? STB_CYC : NAP_CYC)));

    // R3
    conv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (!nap_o && !stby_o && state_o != 2'd3));

    // R2
    sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && sleep_req) |=> (nap_o != stby_o));

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && sleep_req) |=> (nap_o || stby_o));

    // R9
    stby_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stby_o) |-> (state_o == 2'd3));

endmodule

// File: tb/adc_power_seq_test.sv
`timescale 1ns/1ps
module adc_power_seq_test;

    localparam int unsigned HZ     = 33_000_000;
    localparam int unsigned NAP_NS = 300;     // 9.9 cycles -> 10
    localparam int unsigned INT_NS = 40_000;  // 1320 cycles
    localparam int unsigned EXT_NS = 8_000;   // 264 cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 0, sleep_deep = 0, wake_req = 0, auto_nap_en = 0, conv_req = 0, frame_done = 0;
    logic       cs_w[2], rdy_w[2], nap_w[2], stb_w[2];
    logic [1:0] st_w[2];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_power_seq #(.CLK_HZ(HZ), .NAP_WAKE_NS(NAP_NS), .STBY_INT_WAKE_NS(INT_NS),
                    .STBY_EXT_WAKE_NS(EXT_NS), .EXT_REF(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_deep(sleep_deep),
        .wake_req(wake_req), .auto_nap_en(auto_nap_en), .conv_req(conv_req),
        .frame_done(frame_done), .conv_start_o(cs_w[0]), .ready_o(rdy_w[0]),
        .nap_o(nap_w[0]), .stby_o(stb_w[0]), .state_o(st_w[0]));

    adc_power_seq #(.CLK_HZ(HZ), .NAP_WAKE_NS(NAP_NS), .STBY_INT_WAKE_NS(INT_NS),
                    .STBY_EXT_WAKE_NS(EXT_NS), .EXT_REF(1'b1)) uut_ext (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_deep(sleep_deep),
        .wake_req(wake_req), .auto_nap_en(auto_nap_en), .conv_req(conv_req),
        .frame_done(frame_done), .conv_start_o(cs_w[1]), .ready_o(rdy_w[1]),
        .nap_o(nap_w[1]), .stby_o(stb_w[1]), .state_o(st_w[1]));

    function automatic int exp_cycles(input longint unsigned ns);
        longint unsigned c;
        c = (ns * HZ + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 1 : int'(c);
    endfunction

    int n_nap, n_stb[2];

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_state(input string req, input int exp);
        for (int i = 0; i < 2; i++) begin
            chk(req, $sformatf("state_o[%0d]", i), st_w[i], exp);
            chk(req, $sformatf("nap_o[%0d]", i), nap_w[i], exp == 1);
            chk(req, $sformatf("stby_o[%0d]", i), stb_w[i], exp == 2);
            chk(req, $sformatf("ready_o[%0d]", i), rdy_w[i], exp == 0);
        end
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 3000; k++) begin
            if (rdy_w[0] && rdy_w[1]) break;
            tick();
        end
    endtask

    // Count cycles from the entry edge into settling until ready on each instance
    task automatic measure(output int c0, output int c1);
        c0 = -1; c1 = -1;
        for (int k = 1; k <= 3000; k++) begin
            tick();
            if (rdy_w[0] && c0 < 0) c0 = k;
            if (rdy_w[1] && c1 < 0) c1 = k;
            if (c0 >= 0 && c1 >= 0) break;
        end
    endtask

    // Reference model for the random phase
    int m_st[2], m_rem[2];
    bit m_fd[2], m_pend[2];

    task automatic model_edge(input int i, input bit cs);
        bit np;
        case (m_st[i])
            0: begin
                np = auto_nap_en && (m_pend[i] || cs);
                if (sleep_req) begin
                    m_st[i] = sleep_deep ? 2 : 1; np = 0;
                end else if (frame_done && m_pend[i] && auto_nap_en) begin
                    m_st[i] = 1; np = 0;
                end
                m_pend[i] = np;
            end
            1: begin
                if (sleep_req && sleep_deep) m_st[i] = 2;
                else if (!sleep_req && wake_req) begin
                    m_st[i] = 3; m_rem[i] = n_nap; m_fd[i] = 0;
                end
            end
            2: begin
                if (!sleep_req && wake_req) begin
                    m_st[i] = 3; m_rem[i] = n_stb[i]; m_fd[i] = 1;
                end
            end
            default: begin
                if (sleep_req) m_st[i] = (sleep_deep || m_fd[i]) ? 2 : 1;
                else begin
                    m_rem[i]--;
                    if (m_rem[i] == 0) m_st[i] = 0;
                end
            end
        endcase
    endtask

    initial begin
        #(4 * 150_000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0, c1;
        int unsigned seed;
        n_nap = exp_cycles(NAP_NS);
        n_stb[0] = exp_cycles(INT_NS);
        n_stb[1] = exp_cycles(EXT_NS);
        seed = 32'h5EED_0C1A;
        void'($urandom(seed));

        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        chk_state("R1", 0);

        // R3: accepted while awake
        conv_req = 1; #1;
        chk("R3", "conv_start awake[0]", cs_w[0], 1);
        chk("R3", "conv_start awake[1]", cs_w[1], 1);
        tick(); conv_req = 0;

        // R2 light sleep
        sleep_req = 1; sleep_deep = 0; tick(); sleep_req = 0;
        chk_state("R2", 1);
        conv_req = 1; #1;
        chk("R3", "conv_start in nap[0]", cs_w[0], 0);
        chk("R3", "conv_start in nap[1]", cs_w[1], 0);
        tick(); conv_req = 0;

        // R9 nap -> standby, standby ignores nap request
        sleep_req = 1; sleep_deep = 1; tick();
        chk_state("R9", 2);
        sleep_deep = 0; tick(); sleep_req = 0;
        chk_state("R9", 2);

        // R10 sleep beats wake
        sleep_req = 1; sleep_deep = 1; wake_req = 1; tick();
        sleep_req = 0; wake_req = 0;
        chk_state("R10", 2);

        // R5 / R6 standby recovery
        wake_req = 1; tick(); wake_req = 0;
        chk_state("R12", 3);
        measure(c0, c1);
        chk("R5", "standby wake cycles internal ref", c0, n_stb[0]);
        chk("R6", "standby wake cycles external ref", c1, n_stb[1]);
        chk("R6", "external shorter than internal", c1 < c0, 1);

        // R4 / R7 nap recovery with rounding up 9.9 -> 10
        sleep_req = 1; sleep_deep = 0; tick(); sleep_req = 0;
        wake_req = 1; tick(); wake_req = 0;
        measure(c0, c1);
        chk("R4", "nap wake cycles[0]", c0, n_nap);
        chk("R7", "nap wake rounded up[1]", c1, 10);

        // R8 abort standby-wake with nap request -> standby
        sleep_req = 1; sleep_deep = 1; tick(); sleep_req = 0;
        wake_req = 1; tick(); wake_req = 0;
        repeat (3) tick();
        sleep_req = 1; sleep_deep = 0; tick(); sleep_req = 0;
        chk_state("R8", 2);
        wake_req = 1; tick(); wake_req = 0;
        wait_ready();

        // R8 abort nap-wake with nap request -> nap
        sleep_req = 1; sleep_deep = 0; tick(); sleep_req = 0;
        wake_req = 1; tick(); wake_req = 0;
        repeat (2) tick();
        sleep_req = 1; sleep_deep = 0; tick(); sleep_req = 0;
        chk_state("R8", 1);
        // R8 abort nap-wake with deep request -> standby
        wake_req = 1; tick(); wake_req = 0;
        repeat (2) tick();
        sleep_req = 1; sleep_deep = 1; tick(); sleep_req = 0;
        chk_state("R8", 2);
        wake_req = 1; tick(); wake_req = 0;
        wait_ready();

        // R11 auto-nap
        auto_nap_en = 0; conv_req = 1; tick(); conv_req = 0;
        frame_done = 1; tick(); frame_done = 0;
        chk_state("R11", 0);
        auto_nap_en = 1; tick();
        frame_done = 1; tick(); frame_done = 0;
        chk_state("R11", 0);
        conv_req = 1; #1;
        chk("R3", "conv_start auto[0]", cs_w[0], 1);
        tick(); conv_req = 0;
        repeat (2) tick();
        frame_done = 1; tick(); frame_done = 0;
        chk_state("R11", 1);
        auto_nap_en = 0;
        wake_req = 1; tick(); wake_req = 0;
        wait_ready();
        chk_state("R4", 0);

        // Random phase against the model
        for (int i = 0; i < 2; i++) begin
            m_st[i] = 0; m_rem[i] = 0; m_fd[i] = 0; m_pend[i] = 0;
        end
        for (int cyc = 0; cyc < 8000; cyc++) begin
            tick();
            for (int i = 0; i < 2; i++) begin
                chk("R12", $sformatf("rand state[%0d]", i), st_w[i], m_st[i]);
                chk("R2", $sformatf("rand nap[%0d]", i), nap_w[i], m_st[i] == 1);
                chk("R9", $sformatf("rand stby[%0d]", i), stb_w[i], m_st[i] == 2);
                chk("R5", $sformatf("rand ready[%0d]", i), rdy_w[i], m_st[i] == 0);
            end
            sleep_req   = ($urandom % 64) == 0;
            sleep_deep  = $urandom % 2;
            wake_req    = ($urandom % 8) == 0;
            conv_req    = ($urandom % 4) == 0;
            frame_done  = ($urandom % 8) == 0;
            if (($urandom % 256) == 0) auto_nap_en = ~auto_nap_en;
            #1;
            for (int i = 0; i < 2; i++) begin
                bit ecs;
                ecs = conv_req && (m_st[i] == 0);
                chk("R3", $sformatf("rand conv_start[%0d]", i), cs_w[i], ecs);
                model_edge(i, ecs);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule